// File: doc/BRIEF.md
# Clear-to-Send Character Gate for a Serial Transmitter

This block decides, character by character, whether a serial transmitter may move the next byte from its transmit FIFO into the shift register. It runs its own half-bit position counter over each character. At one fixed point near the end of the character it samples an already-synchronized clear-to-send level. That decision then governs the next character boundary. The character being shifted always runs to its end, whatever the clear-to-send input does while it is on the line.

The response to a lost clear-to-send depends on the mode. In asynchronous mode the transmitter only pauses, and it picks up again by itself once clear-to-send comes back. In framed (synchronous) mode the message is dropped. A sticky terminated flag is raised, and nothing more is sent until software issues a start-of-message command with clear-to-send present. A transmitter reset puts the gate back into idle and requests a FIFO flush. Software is expected to issue this reset before it sends an aborted message again.

The controller has five states:
- `ST_IDLE`: nothing in flight.
- `ST_ARMED`: a framed message has been started and is waiting for its first character.
- `ST_SHIFT`: a character is on the line.
- `ST_HOLD`: asynchronous pause.
- `ST_TERM`: a framed message was aborted.

Its transitions are:
- IDLE→SHIFT: asynchronous start.
- IDLE→ARMED: start-of-message in framed mode.
- ARMED→SHIFT: first load.
- SHIFT→SHIFT: next load.
- SHIFT→IDLE: FIFO ran dry.
- SHIFT→HOLD: asynchronous loss.
- SHIFT→TERM: framed loss.
- HOLD→SHIFT: resume.
- HOLD→IDLE: resume with an empty FIFO.
- TERM→ARMED: start-of-message.
- any→IDLE: transmitter reset.

Top module: `tx_cts_gate`

## Requirements
- R1: After rst_n is released, load_next, flush_req and terminated are all 0.
- R2: In asynchronous mode (mode_framed=0), idle, with cts_ok=1 and fifo_avail=1, load_next is high in the same cycle as the next half_tick and for that cycle only.
- R3: While clear-to-send holds and data stays available, successive load_next pulses are exactly 2*CHAR_BITS half_ticks apart. A character in flight is never cut short.
- R4: Within a character, cts_ok is sampled only on the half_tick that comes three half_ticks (1.5 bit times) before the next boundary. Its level on every other half_tick of that character has no effect on that boundary.
- R5: In asynchronous mode, if that sample saw cts_ok=0, no load occurs at the boundary. The first later half_tick with cts_ok=1 and fifo_avail=1 then loads, with no command needed.
- R6: In framed mode, if that sample saw cts_ok=0, no load occurs at the boundary, and terminated reads 1 from the following cycle.
- R7: In framed mode, a message starts only after som_cmd. While terminated, no load occurs however long cts_ok stays 1. A som_cmd clears terminated on the next cycle and arms the gate, and the next half_tick with cts_ok=1 and fifo_avail=1 loads.
- R8: No load occurs while fifo_avail=0. When the FIFO is empty at a boundary the gate goes idle without setting terminated, and in asynchronous mode it restarts on the first half_tick after data returns.
- R9: flush_req equals tx_reset in the same cycle. A reset abandons any character in flight and returns the gate to idle (framed mode then needs a new som_cmd). It leaves terminated unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_ok | input | 1 | Synchronized clear-to-send, 1 = asserted |
| mode_framed | input | 1 | 0 = asynchronous, 1 = framed/synchronous |
| som_cmd | input | 1 | Start-of-message command pulse |
| tx_reset | input | 1 | Transmitter reset pulse |
| half_tick | input | 1 | One pulse per half bit time |
| fifo_avail | input | 1 | Transmit FIFO holds at least one character |
| load_next | output | 1 | Move next character into the shift register (one cycle) |
| flush_req | output | 1 | Request to empty the transmit FIFO |
| terminated | output | 1 | Framed message aborted on clear-to-send loss |

## Verification
The bench builds the gate with CHAR_BITS=4, so a character lasts eight half_ticks and the clear-to-send sample falls on the fifth. Each boundary, hold, abort and restart is therefore only a few dozen clocks away. With this size the run can place a clear-to-send drop exactly on the sampling tick, or on every other tick of the same character, and show the gap between the two outcomes many times. A behavioural model predicts load_next, flush_req and terminated on every clock.

// File: rtl/tx_cts_pkg.sv
package tx_cts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_TERM  = 3'd4
    } txg_state_e;

endpackage

// File: rtl/tx_cts_halfcnt.sv
// Half-bit position counter across one character on the line.
module tx_cts_halfcnt #(
    parameter  int CHAR_BITS = 8,
    localparam int HALVES    = 2 * CHAR_BITS,
    localparam int CW        = $clog2(HALVES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          half_tick,
    output logic [CW-1:0] count,
    output logic          at_check,
    output logic          at_end
);

    localparam logic [CW-1:0] LAST     = CW'(HALVES - 1);
    localparam logic [CW-1:0] CHECK_AT = CW'(HALVES - 4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (run && half_tick) begin
            if (count == LAST) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    always_comb begin
        at_end   = (count == LAST);
        at_check = (count == CHECK_AT);
    end

endmodule

// File: rtl/tx_cts_probe.sv
// Holds the clear-to-send decision taken at the sampling point.
module tx_cts_probe (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic sample,
    input  logic cts_ok,
    output logic go
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go <= 1'b0;
        end else if (flush) begin
            go <= 1'b0;
        end else if (sample) begin
            go <= cts_ok;
        end
    end

endmodule

// File: rtl/tx_cts_seq.sv
// Character-gating state machine.
module tx_cts_seq
    import tx_cts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_framed,
    input  logic       som_cmd,
    input  logic       tx_reset,
    input  logic       half_tick,
    input  logic       cts_ok,
    input  logic       fifo_avail,
    input  logic       at_end,
    input  logic       go,
    output txg_state_e state,
    output logic       load_next,
    output logic       terminated
);

    txg_state_e nxt;
    logic       abort;

    // state register and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            terminated <= 1'b0;
        end else begin
            state <= nxt;
            if (abort) begin
                terminated <= 1'b1;
            end else if (som_cmd) begin
                terminated <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        load_next = 1'b0;
        abort     = 1'b0;
        if (!tx_reset && half_tick) begin
            unique case (state)
                ST_IDLE:  load_next = fifo_avail && cts_ok && !mode_framed;
                ST_ARMED: load_next = fifo_avail && cts_ok;
                ST_HOLD:  load_next = fifo_avail && cts_ok;
                ST_SHIFT: begin
                    load_next = fifo_avail && at_end && go;
                    abort     = at_end && !go && mode_framed;
                end
                ST_TERM:  load_next = 1'b0;
                default:  load_next = 1'b0;
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (tx_reset) begin
            nxt = ST_IDLE;
        end else if (load_next) begin
            nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mode_framed && som_cmd) nxt = ST_ARMED;
                end
                ST_ARMED: nxt = ST_ARMED;
                ST_SHIFT: begin
                    if (half_tick && at_end) begin
                        if (go)               nxt = ST_IDLE;
                        else if (mode_framed) nxt = ST_TERM;
                        else                  nxt = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (half_tick && cts_ok && !fifo_avail) nxt = ST_IDLE;
                end
                ST_TERM: begin
                    if (som_cmd) nxt = ST_ARMED;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // R7: an aborted message can not emit characters
    p_term_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERM) |-> !load_next);

    // R6: the abort state always carries the flag
    p_term_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERM) |-> terminated);

endmodule

// File: rtl/tx_cts_gate.sv
module tx_cts_gate
    import tx_cts_pkg::*;
#(
    parameter int CHAR_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_ok,
    input  logic mode_framed,
    input  logic som_cmd,
    input  logic tx_reset,
    input  logic half_tick,
    input  logic fifo_avail,
    output logic load_next,
    output logic flush_req,
    output logic terminated
);

    localparam int HALVES = 2 * CHAR_BITS;
    localparam int CW     = $clog2(HALVES);
    localparam logic [CW-1:0] LAST = CW'(HALVES - 1);

    txg_state_e    state;
    logic [CW-1:0] hcnt;
    logic          at_check;
    logic          at_end;
    logic          go;
    logic          in_shift;

    assign in_shift  = (state == ST_SHIFT);
    assign flush_req = tx_reset;

    tx_cts_halfcnt #(.CHAR_BITS(CHAR_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_reset || load_next),
        .run      (in_shift),
        .half_tick(half_tick),
        .count    (hcnt),
        .at_check (at_check),
        .at_end   (at_end)
    );

    tx_cts_probe u_probe (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_reset),
        .sample(in_shift && half_tick && at_check),
        .cts_ok(cts_ok),
        .go    (go)
    );

    tx_cts_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_framed(mode_framed),
        .som_cmd    (som_cmd),
        .tx_reset   (tx_reset),
        .half_tick  (half_tick),
        .cts_ok     (cts_ok),
        .fifo_avail (fifo_avail),
        .at_end     (at_end),
        .go         (go),
        .state      (state),
        .load_next  (load_next),
        .terminated (terminated)
    );

    // R3: a load restarts the character position
    p_restart_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_next |=> (hcnt == '0));

    // R3: position never leaves the character
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= LAST);

    // R4: decision moves only on the sampling tick
    p_sample_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_shift && !(half_tick && at_check) && !tx_reset) |=> $stable(go));

    // R6: the flag rises only after a framed boundary with a negative decision
    p_abort_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(terminated) |-> $past(half_tick && !go && mode_framed));

    // R7: a start command off the tick clears the flag
    p_som_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (som_cmd && !half_tick) |=> !terminated);

    // R9: reset drops the position and the decision
    p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> ((hcnt == '0) && !go));

endmodule

// File: tb/tx_cts_gate_tb.sv
module tx_cts_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CB         = 4;
    localparam int H          = 2 * CB;
    localparam int TICK_GAP   = 4;

    localparam int M_IDLE  = 0;
    localparam int M_ARMED = 1;
    localparam int M_SHIFT = 2;
    localparam int M_HOLD  = 3;
    localparam int M_TERM  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_ok = 1'b0;
    logic mode_framed = 1'b0;
    logic som_cmd = 1'b0;
    logic tx_reset = 1'b0;
    logic half_tick = 1'b0;
    logic fifo_avail = 1'b0;
    logic load_next;
    logic flush_req;
    logic terminated;

    int    total = 0;
    int    bad = 0;
    int    dut_loads = 0;
    bit    done = 1'b0;
    bit    last_flush = 1'b0;
    string cur_req = "R2";

    int m_st = M_IDLE;
    int m_cnt = 0;
    bit m_go = 1'b0;
    bit m_term = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_cts_gate #(.CHAR_BITS(CB)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_ok     (cts_ok),
        .mode_framed(mode_framed),
        .som_cmd    (som_cmd),
        .tx_reset   (tx_reset),
        .half_tick  (half_tick),
        .fifo_avail (fifo_avail),
        .load_next  (load_next),
        .flush_req  (flush_req),
        .terminated (terminated)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_load();
        if (tx_reset || !half_tick || !fifo_avail) return 1'b0;
        case (m_st)
            M_IDLE:  return cts_ok && !mode_framed;
            M_ARMED: return cts_ok;
            M_HOLD:  return cts_ok;
            M_SHIFT: return (m_cnt == H - 1) && m_go;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step();
        bit ld = exp_load();
        bit nt = m_term;
        if (som_cmd) nt = 1'b0;
        if (tx_reset) begin
            m_st = M_IDLE; m_cnt = 0; m_go = 1'b0;
        end else if (ld) begin
            m_st = M_SHIFT; m_cnt = 0;
        end else begin
            case (m_st)
                M_IDLE:  if (mode_framed && som_cmd) m_st = M_ARMED;
                M_HOLD:  if (half_tick && cts_ok && !fifo_avail) m_st = M_IDLE;
                M_TERM:  if (som_cmd) m_st = M_ARMED;
                M_SHIFT: if (half_tick) begin
                    if (m_cnt == H - 4) m_go = cts_ok;
                    if (m_cnt == H - 1) begin
                        m_cnt = 0;
                        if (m_go) m_st = M_IDLE;
                        else if (mode_framed) begin m_st = M_TERM; nt = 1'b1; end
                        else m_st = M_HOLD;
                    end else begin
                        m_cnt++;
                    end
                end
                default: ;
            endcase
        end
        m_term = nt;
    endtask

    task automatic cyc(bit tk);
        @(negedge clk);
        half_tick = tk;
        #1;
        check(cur_req, "load_next", int'(load_next), int'(exp_load()));
        check("R9", "flush_req", int'(flush_req), int'(tx_reset));
        check("R6", "terminated", int'(terminated), int'(m_term));
        if (load_next) dut_loads++;
        last_flush = flush_req;
        @(posedge clk);
        #1;
        model_step();
        half_tick = 1'b0;
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1);
            repeat (TICK_GAP - 1) cyc(1'b0);
        end
    endtask

    task automatic pulse_som();
        som_cmd = 1'b1;
        cyc(1'b0);
        som_cmd = 1'b0;
    endtask

    task automatic pulse_rst();
        tx_reset = 1'b1;
        cyc(1'b0);
        tx_reset = 1'b0;
    endtask

    initial begin
        int l0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "load_next after reset", int'(load_next), 0);
        check("R1", "flush_req after reset", int'(flush_req), 0);
        check("R1", "terminated after reset", int'(terminated), 0);
        @(posedge clk);
        #1;

        // R2 / R3: asynchronous stream
        cts_ok = 1'b1; fifo_avail = 1'b1; cur_req = "R2";
        l0 = dut_loads; tick_n(1);
        check("R2", "first load on first tick", dut_loads - l0, 1);
        cur_req = "R3";
        l0 = dut_loads; tick_n(19);
        check("R3", "loads over 19 more ticks", dut_loads - l0, 2);

        // R4: clear-to-send low everywhere but the sampling tick
        cur_req = "R4";
        cts_ok = 1'b0; tick_n(1);
        cts_ok = 1'b1; tick_n(1);
        cts_ok = 1'b0; tick_n(2);
        l0 = dut_loads; tick_n(1);
        check("R4", "boundary load despite low outside sample", dut_loads - l0, 1);
        cts_ok = 1'b1;

        // R5: asynchronous hold and self-resume
        cur_req = "R5";
        tick_n(4);
        cts_ok = 1'b0; tick_n(1);
        cts_ok = 1'b1;
        l0 = dut_loads; tick_n(3);
        check("R5", "no load after negative sample", dut_loads - l0, 0);
        cts_ok = 1'b0;
        l0 = dut_loads; tick_n(5);
        check("R5", "no load while held", dut_loads - l0, 0);
        cts_ok = 1'b1;
        l0 = dut_loads; tick_n(1);
        check("R5", "resume on return", dut_loads - l0, 1);

        // R8: empty FIFO
        cur_req = "R8";
        tick_n(7);
        fifo_avail = 1'b0;
        l0 = dut_loads; tick_n(6);
        check("R8", "no load while FIFO empty", dut_loads - l0, 0);
        check("R8", "no terminated on drain", int'(terminated), 0);
        fifo_avail = 1'b1;
        l0 = dut_loads; tick_n(1);
        check("R8", "restart when data returns", dut_loads - l0, 1);
        tick_n(7);
        fifo_avail = 1'b0; tick_n(1);

        // R7: framed idle needs a start command
        cur_req = "R7";
        mode_framed = 1'b1; fifo_avail = 1'b1;
        l0 = dut_loads; tick_n(6);
        check("R7", "no framed load without som", dut_loads - l0, 0);
        pulse_som();
        l0 = dut_loads; tick_n(1);
        check("R7", "framed load after som", dut_loads - l0, 1);

        // R6: framed abort
        cur_req = "R6";
        tick_n(4);
        cts_ok = 1'b0; tick_n(1);
        cts_ok = 1'b1;
        l0 = dut_loads; tick_n(3);
        check("R6", "no load at aborted boundary", dut_loads - l0, 0);
        check("R6", "terminated raised", int'(terminated), 1);

        // R7: restart rule
        cur_req = "R7";
        l0 = dut_loads; tick_n(8);
        check("R7", "no load while terminated", dut_loads - l0, 0);
        check("R7", "terminated still set", int'(terminated), 1);
        pulse_som();
        check("R7", "som clears terminated", int'(terminated), 0);
        l0 = dut_loads; tick_n(1);
        check("R7", "load after som", dut_loads - l0, 1);

        // R9: reset behaviour
        cur_req = "R9";
        tick_n(4);
        cts_ok = 1'b0; tick_n(1);
        cts_ok = 1'b1; tick_n(3);
        check("R9", "terminated before reset", int'(terminated), 1);
        pulse_rst();
        check("R9", "flush_req during reset", int'(last_flush), 1);
        check("R9", "terminated kept by reset", int'(terminated), 1);
        pulse_som();
        l0 = dut_loads; tick_n(1);
        check("R9", "load after som", dut_loads - l0, 1);
        tick_n(3);
        pulse_rst();
        l0 = dut_loads; tick_n(10);
        check("R9", "no load after mid-char reset", dut_loads - l0, 0);
        pulse_som();
        l0 = dut_loads; tick_n(1);
        check("R9", "restart after reset and som", dut_loads - l0, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule